// File: doc/BRIEF.md
# Two-to-five lane gearbox

The block takes two independent serial lanes that run at a common bit rate and spreads their bits over five output lanes. Each output lane runs at two fifths of the input lane rate. Everything runs on one base clock at twice the input bit rate. An input lane delivers a new bit on every second base cycle, and an output lane holds each bit for five base cycles. This makes the noninteger 2:5 ratio an exact integer schedule over a frame of 20 base cycles, and a free-running phase counter produces that schedule.

The conversion runs in two steps per lane. First, a 1:2 split forms aligned even/odd pairs. Second, a 1:5 split places each half-rate stream into five slot registers. The slots are retimed in two groups on phases half a frame apart. After that, all 20 slow lines hold one complete frame. A holding register and five 4:1 selectors rebuild the output lanes. The middle selector takes two lines from each input lane. A frame strobe marks the first output bit of every frame, and a valid flag rises once the first full frame reaches the outputs.

Top module: `gearbox_2to5`

## Requirements
- R1: A synchronous active-high `rst` clears the phase counter and every data register. From the first edge after `rst` is seen, `dout`, `frame_strobe` and `dout_valid` are all 0.
- R2: Counting edges from the first edge with `rst` low as edge 0, input lanes are sampled on even edges only. Edge 2k of frame f (edges 20f .. 20f+19) carries bit k (k = 0..9) of that frame on both lanes.
- R3: Output lane o carries, in order m = 0..3, aggregate bit 4o+m of a frame. Aggregate bits 0..9 are lane 0 bits 0..9, and aggregate bits 10..19 are lane 1 bits 0..9. Outputs 0 and 1 therefore carry only lane 0 data, and outputs 3 and 4 carry only lane 1 data.
- R4: Output lane 2 carries lane 0 bits 8 and 9, then lane 1 bits 0 and 1.
- R5: `dout` changes only on edges whose index modulo 20 is 3, 8, 13 or 18. Each output bit is held for five base cycles.
- R6: Bit m of frame F appears after edge 20(F+1)+8+5m. Bit 0 of frame 0 is visible 28 edges after edge 0.
- R7: `frame_strobe` is a one-cycle pulse after edges 20(F+1)+8 (F >= 0). It coincides with bit 0 of frame F on `dout` and is never high on two consecutive cycles.
- R8: `dout_valid` rises together with the first `frame_strobe` and stays high until reset. `dout` is 0 while it is low.
- R9: Values on `lane_in` at odd edges have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, twice the input lane bit rate |
| rst | input | 1 | Synchronous active-high reset |
| lane_in | input | 2 | Serial input lanes, bit 0 = lane 0, bit 1 = lane 1 |
| dout | output | 5 | Five output lanes, bit o = output lane o |
| frame_strobe | output | 1 | One-cycle marker of output bit 0 of a frame |
| dout_valid | output | 1 | High once the first complete frame is on the outputs |

## Verification
The hardest case to reach from the ports is a bit that has to cross from one input lane into the middle output while the two retime groups have updated at different phases. A walking single one visits all 20 aggregate positions, one per frame. This shows that each bit lands on exactly one output slot. A stimulus with lane 0 all ones and lane 1 all zeros isolates the middle output's two-and-two split. Random junk is driven on every odd edge so that any sampling on the wrong phase shows up. A reset in the middle of a run checks that the frame schedule and the valid latency start again from edge 0.

// File: rtl/gb25_pkg.sv
`timescale 1ns/1ps
package gb25_pkg;
  localparam int LANES_IN    = 2;
  localparam int SLOTS       = 5;
  localparam int OUT_LANES   = 5;
  localparam int MUX_W       = 4;
  localparam int CYC_PER_BIT = 2;
  localparam int LANE_BITS   = 2 * SLOTS;
  localparam int FRAME_BITS  = LANES_IN * LANE_BITS;
  localparam int FRAME_CYC   = LANE_BITS * CYC_PER_BIT;
  localparam int HOLD_CYC    = FRAME_CYC / MUX_W;
  localparam int PH_W        = $clog2(FRAME_CYC);
  localparam int SEL_W       = $clog2(MUX_W);
  localparam int PAIR_CYC    = 2 * CYC_PER_BIT;

  // slots retimed on phase A; the rest half a frame later on phase B
  localparam logic [SLOTS-1:0] GROUP_A_MASK = 5'b01011;
  localparam int RT_A      = PAIR_CYC * 3 + PAIR_CYC;
  localparam int RT_B      = (RT_A + FRAME_CYC / 2) % FRAME_CYC;
  localparam int LOAD_PH   = RT_B + 1;
  localparam int FIRST_OUT = LOAD_PH + 1;

  function automatic int slot_phase(input int j);
    return PAIR_CYC * j + PAIR_CYC - 1;
  endfunction

  function automatic int out_offset(input int ph);
    return (ph - FIRST_OUT + FRAME_CYC) % FRAME_CYC;
  endfunction

  function automatic bit is_out_tick(input int ph);
    return (out_offset(ph) % HOLD_CYC) == 0;
  endfunction

  function automatic int out_slot(input int ph);
    return out_offset(ph) / HOLD_CYC;
  endfunction
endpackage

// File: rtl/gb25_phase.sv
`timescale 1ns/1ps
module gb25_phase
  import gb25_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic            in_take
);
  always_ff @(posedge clk) begin
    if (rst)                             ph <= '0;
    else if (ph == PH_W'(FRAME_CYC - 1)) ph <= '0;
    else                                 ph <= ph + 1'b1;
  end

  assign in_take = (int'(ph) % CYC_PER_BIT) == 0;
endmodule

// File: rtl/gb25_lane_front.sv
`timescale 1ns/1ps
module gb25_lane_front
  import gb25_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PH_W-1:0]      ph,
  input  logic                 in_take,
  input  logic                 din,
  output logic [LANE_BITS-1:0] lines
);
  logic             even_hold;
  logic             pair_e, pair_o;
  logic [SLOTS-1:0] slot_e, slot_o;
  logic [SLOTS-1:0] line_e, line_o;
  logic             even_ce, pair_ce;

  assign even_ce = in_take && ((int'(ph) % PAIR_CYC) == 0);
  assign pair_ce = in_take && ((int'(ph) % PAIR_CYC) == CYC_PER_BIT);

  // 1:2 split, both outputs launched on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      even_hold <= 1'b0;
      pair_e    <= 1'b0;
      pair_o    <= 1'b0;
    end else begin
      if (even_ce) even_hold <= din;
      if (pair_ce) begin
        pair_e <= even_hold;
        pair_o <= din;
      end
    end
  end

  // 1:5 sequential sampling, then two-phase retiming
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_e <= '0;
      slot_o <= '0;
      line_e <= '0;
      line_o <= '0;
    end else begin
      for (int j = 0; j < SLOTS; j++) begin
        if (int'(ph) == slot_phase(j)) begin
          slot_e[j] <= pair_e;
          slot_o[j] <= pair_o;
        end
        if (int'(ph) == (GROUP_A_MASK[j] ? RT_A : RT_B)) begin
          line_e[j] <= slot_e[j];
          line_o[j] <= slot_o[j];
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      lines[2*j]   = line_e[j];
      lines[2*j+1] = line_o[j];
    end
  end
endmodule

// File: rtl/gb25_mux_out.sv
`timescale 1ns/1ps
module gb25_mux_out
  import gb25_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PH_W-1:0]       ph,
  input  logic [FRAME_BITS-1:0] lines_all,
  output logic [OUT_LANES-1:0]  dout,
  output logic                  frame_strobe,
  output logic                  dout_valid,
  output logic                  out_tick
);
  logic [FRAME_BITS-1:0] hold;
  logic [SEL_W-1:0]      sel;
  logic [OUT_LANES-1:0]  pick;
  logic                  primed;
  logic                  first_bit;

  assign out_tick  = is_out_tick(int'(ph));
  assign sel       = SEL_W'(out_slot(int'(ph)));
  assign first_bit = (ph == PH_W'(FIRST_OUT)) && primed;

  genvar o;
  generate
    for (o = 0; o < OUT_LANES; o++) begin : g_sel
      logic [MUX_W-1:0] grp;
      assign grp     = hold[o*MUX_W +: MUX_W];
      assign pick[o] = grp[sel];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hold         <= '0;
      dout         <= '0;
      primed       <= 1'b0;
      frame_strobe <= 1'b0;
      dout_valid   <= 1'b0;
    end else begin
      if (ph == PH_W'(LOAD_PH))       hold   <= lines_all;
      if (out_tick)                   dout   <= pick;
      if (ph == PH_W'(FRAME_CYC - 1)) primed <= 1'b1;
      frame_strobe <= first_bit;
      if (first_bit) dout_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/gearbox_2to5.sv
`timescale 1ns/1ps
module gearbox_2to5
  import gb25_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANES_IN-1:0]  lane_in,
  output logic [OUT_LANES-1:0] dout,
  output logic                 frame_strobe,
  output logic                 dout_valid
);
  logic [PH_W-1:0]       ph;
  logic                  in_take;
  logic                  out_tick;
  logic [FRAME_BITS-1:0] lines_all;

  gb25_phase u_phase (
    .clk(clk), .rst(rst), .ph(ph), .in_take(in_take)
  );

  genvar l;
  generate
    for (l = 0; l < LANES_IN; l++) begin : g_lane
      gb25_lane_front u_front (
        .clk(clk), .rst(rst), .ph(ph), .in_take(in_take),
        .din(lane_in[l]),
        .lines(lines_all[l*LANE_BITS +: LANE_BITS])
      );
    end
  endgenerate

  gb25_mux_out u_mux (
    .clk(clk), .rst(rst), .ph(ph), .lines_all(lines_all),
    .dout(dout), .frame_strobe(frame_strobe),
    .dout_valid(dout_valid), .out_tick(out_tick)
  );
endmodule

// File: rtl/gearbox_2to5_chk.sv
`timescale 1ns/1ps
module gearbox_2to5_chk
  import gb25_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_take,
  input logic                 out_tick,
  input logic [OUT_LANES-1:0] dout,
  input logic                 frame_strobe,
  input logic                 dout_valid
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dout == '0 && !frame_strobe && !dout_valid));

  // R2
  take_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    in_take |=> !in_take);

  // R5
  dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_tick |=> $stable(dout));

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |=> !frame_strobe);

  // R7
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_strobe) |-> $past(out_tick));

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> dout_valid);

  // R8
  strobe_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> dout_valid);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_valid |-> dout == '0);
endmodule

bind gearbox_2to5 gearbox_2to5_chk u_chk (
  .clk(clk), .rst(rst), .in_take(in_take), .out_tick(out_tick),
  .dout(dout), .frame_strobe(frame_strobe), .dout_valid(dout_valid)
);

// File: tb/gearbox_2to5_test.sv
`timescale 1ns/1ps
module gearbox_2to5_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] lane_in = 2'b00;
  logic [4:0] dout;
  logic       frame_strobe, dout_valid;

  int   tests = 0;
  int   fails = 0;
  bit   done  = 0;
  bit   q0[$];
  bit   q1[$];
  logic [4:0] prev_dout;

  always #2.5 clk = ~clk;

  gearbox_2to5 uut (
    .clk(clk), .rst(rst), .lane_in(lane_in),
    .dout(dout), .frame_strobe(frame_strobe), .dout_valid(dout_valid)
  );

  task automatic report(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference bit for lane ln, frame f, position k
  function automatic bit stim_bit(int pat, int ln, int f, int k);
    int p;
    case (pat)
      1: return 1'b1;
      2: return ((k % 2) == 0) ^ (ln == 1);
      3: return (ln == 0);
      4: begin
           p = f % 20;
           return (p == k + 10 * ln);
         end
      default: return 1'($urandom);
    endcase
  endfunction

  task automatic do_reset(string req);
    @(negedge clk);
    rst = 1'b1;
    lane_in = 2'b11;
    repeat (2) @(negedge clk);
    report(dout == 5'd0, req, "dout in reset", int'(dout), 0);
    report(!frame_strobe && !dout_valid, req, "strobe/valid in reset",
           int'({frame_strobe, dout_valid}), 0);
    rst = 1'b0;
    q0.delete();
    q1.delete();
    prev_dout = dout;
  endtask

  // expected outputs after edge e, from R3..R8
  task automatic check_cycle(int e, string label);
    int u, f, m, g;
    logic [4:0] exp_d;
    bit exp_s, exp_v;
    exp_d = '0;
    u = e - ((e + 2) % 5);
    if (u >= 28) begin
      f = (u - 8) / 20 - 1;
      m = ((u - 8) % 20) / 5;
      for (int o = 0; o < 5; o++) begin
        g = 4 * o + m;
        exp_d[o] = (g < 10) ? q0[f*10 + g] : q1[f*10 + g - 10];
      end
    end
    exp_v = (e >= 28);
    exp_s = (e >= 28) && ((e % 20) == 8);
    if (dout[2] != exp_d[2])
      report(1'b0, "R4", {label, " middle lane"}, int'(dout), int'(exp_d));
    else
      report(dout == exp_d, "R3", {label, " dout (R9 junk on odd edges)"},
             int'(dout), int'(exp_d));
    report(frame_strobe == exp_s, "R7", {label, " strobe"},
           int'(frame_strobe), int'(exp_s));
    report(dout_valid == exp_v, "R8", {label, " valid"},
           int'(dout_valid), int'(exp_v));
    if (((e + 2) % 5) != 0)
      report(dout == prev_dout, "R5", {label, " hold between ticks"},
             int'(dout), int'(prev_dout));
    if (e == 28)
      report(dout[0] == q0[0], "R6", {label, " first bit latency"},
             int'(dout[0]), int'(q0[0]));
    prev_dout = dout;
  endtask

  task automatic run(int pat, int frames, string label);
    for (int e = 0; e < frames * 20; e++) begin
      if ((e % 2) == 0) begin
        // R2: sampled edge carries bit k of frame f
        lane_in[0] = stim_bit(pat, 0, e / 20, (e % 20) / 2);
        lane_in[1] = stim_bit(pat, 1, e / 20, (e % 20) / 2);
        q0.push_back(lane_in[0]);
        q1.push_back(lane_in[1]);
      end else begin
        lane_in = 2'($urandom);
      end
      @(posedge clk);
      @(negedge clk);
      check_cycle(e, label);
    end
  endtask

  initial begin
    do_reset("R1");
    run(0, 8, "R3 random");
    do_reset("R1");
    run(1, 6, "R3 all ones");
    do_reset("R1");
    run(2, 6, "R2 alternating");
    do_reset("R1");
    run(3, 6, "R4 lane split");
    do_reset("R1");
    run(4, 22, "R4 walking one");
    do_reset("R1");
    run(0, 3, "R6 before mid reset");
    do_reset("R1 mid-run");
    run(0, 5, "R6 after mid reset");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule